// File: doc/BRIEF.md
# SD Card Multi-Sector Read Sequencer

This block fetches a run of 512-byte sectors from an SD card in SPI mode with no processor help between sectors. A single `start` pulse latches a starting sector address, a sector count and a token search limit. The sequencer lowers chip select and issues the read-many command. It then pulls each sector in turn: it hunts for the start-of-data marker, takes in the payload, and consumes the two checksum bytes. After the last sector it issues the stop command, waits out the card's busy period, releases chip select and pulses `done`.

On the card side it is master of a byte-exchange port. It holds `spi_req` with a byte on `spi_tx` until the SPI shifter answers with `spi_ack` and the byte it shifted in on `spi_rx`. Payload bytes leave on a stream with no backpressure. Each byte is tagged with its position in the sector and with a running sector number.

Three failures end a read early, each with its own code: a read command whose response is non-zero, a response that never arrives, and a data marker that does not show up within the search limit. A search timeout still sends the stop command before chip select is released.

Top module: `sd_mbr_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, and `spi_req`, `done`, `out_valid` and `err_code` are all 0.
- R2: A read first sends the 6-byte frame 0x52, then the four sector-address bytes most significant first, then 0xFF. `spi_cs_n` is low from the first frame byte.
- R3: Every exchange outside a command frame transmits 0xFF.
- R4: After a frame the response is polled with 0xFF fill until a byte with bit 7 clear arrives. If no such byte arrives within `R1_POLL_MAX` (default 8) exchanges, `err_code` is 3. A non-zero response to the read command gives `err_code` 2. Both cases release the card with no stop command and no data.
- R5: Before each sector the engine exchanges until it receives 0xFE. The next 512 received bytes appear on `out_data` with `out_idx` counting 0..511 and `out_sector` counting from 0.
- R6: The hunt lasts at most `tok_limit` exchanges, or 8192 when `tok_limit` is 0. A marker on the last permitted exchange is accepted. Otherwise `err_code` is 1 and the stop command is still sent.
- R7: The two bytes after each payload are consumed and not output. The hunt/payload/checksum cycle repeats until `sector_cnt` sectors have been read.
- R8: After the last sector the frame 0x4C, 0x00 x4, 0xFF is sent and its response polled. Exchanges then continue while the card returns 0x00, and chip select is released after the first non-zero byte.
- R9: `done` is a one-cycle pulse that coincides with `spi_cs_n` going high. `err_code` holds its value until the next `start`.
- R10: A `start` with `sector_cnt` of 0 raises `done` on the next cycle with `err_code` 0 and no exchange.
- R11: `spi_req` and `spi_tx` stay unchanged from the cycle a request begins until `spi_ack` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a read (ignored while one is running) |
| sector_addr | input | 32 | First sector address |
| sector_cnt | input | 16 | Number of sectors to read |
| tok_limit | input | 16 | Max hunt exchanges per sector, 0 selects 8192 |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Exchange complete, `spi_rx` valid |
| spi_rx | input | 8 | Byte received in the completed exchange |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_idx | output | 9 | Byte position within the sector |
| out_sector | output | 16 | Sector number within this read |
| done | output | 1 | Read finished pulse |
| err_code | output | 2 | 0 ok, 1 marker timeout, 2 bad response, 3 no response |

## Verification
The bench drives the engine with a scripted card model that parses the command frames and replies with configurable response delays, marker gaps, busy lengths and shifter latency. Single and multi-sector reads with different gaps and addresses show that payload order, sector tagging and address byte order are correct. Paired runs with the marker one exchange inside and one exchange outside the search limit separate an off-by-one hunt counter from a correct one. The bad-response and silent-card runs, plus a slow shifter, confirm that each error ends on the right path and that requests hold steady while they wait.

// File: rtl/sd_mbr_pkg.sv
package sd_mbr_pkg;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] START_MARK  = 8'hFE;
    localparam logic [5:0] OP_READ_MANY = 6'd18;
    localparam logic [5:0] OP_STOP      = 6'd12;
    localparam int FRAME_LEN    = 6;
    localparam int SECTOR_BYTES = 512;
    localparam int IDX_W        = $clog2(SECTOR_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RESP,
        ST_HUNT,
        ST_DATA,
        ST_CHK,
        ST_BUSY,
        ST_END
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_MARK   = 2'd1,
        ERR_RESP   = 2'd2,
        ERR_SILENT = 2'd3
    } err_e;

    function automatic logic [7:0] opcode_byte(input logic is_stop);
        return {2'b01, (is_stop ? OP_STOP : OP_READ_MANY)};
    endfunction

endpackage

// File: rtl/sd_mbr_cmdgen.sv
module sd_mbr_cmdgen
    import sd_mbr_pkg::*;
(
    input  logic        is_stop,
    input  logic [31:0] arg,
    input  logic [2:0]  pos,
    output logic [7:0]  frame_byte
);

    logic [31:0] arg_eff;
    logic [7:0]  fb [FRAME_LEN];

    assign arg_eff = is_stop ? 32'h0 : arg;
    assign fb[0] = opcode_byte(is_stop);
    assign fb[FRAME_LEN-1] = FILL_BYTE;

    for (genvar g = 1; g <= 4; g++) begin : g_arg
        assign fb[g] = arg_eff[8*(4-g) +: 8];
    end

    always_comb begin
        frame_byte = FILL_BYTE;
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (pos == 3'(i)) frame_byte = fb[i];
        end
    end

endmodule

// File: rtl/sd_mbr_seq.sv
module sd_mbr_seq
    import sd_mbr_pkg::*;
#(
    parameter int SEC_W       = 16,
    parameter int LIM_W       = 16,
    parameter int DEF_LIMIT   = 8192,
    parameter int R1_POLL_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      sector_addr,
    input  logic [SEC_W-1:0] sector_cnt,
    input  logic [LIM_W-1:0] tok_limit,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx,
    output logic             spi_req,
    output logic             in_frame,
    output logic             frame_stop,
    output logic [2:0]       frame_pos,
    output logic [31:0]      frame_arg,
    output logic             cs_low,
    output logic             push,
    output logic [IDX_W-1:0] push_idx,
    output logic [SEC_W-1:0] push_sec,
    output logic             done,
    output logic [1:0]       err_code
);

    localparam logic [LIM_W-1:0] DEF_L     = LIM_W'(DEF_LIMIT);
    localparam logic [LIM_W-1:0] POLL_LAST = LIM_W'(R1_POLL_MAX - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SECTOR_BYTES - 1);

    seq_state_e       st;
    logic             stop_r;
    logic [2:0]       pos_r;
    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] lim_r;
    logic [IDX_W-1:0] idx_r;
    logic             chk_k;
    logic [SEC_W-1:0] sec_left;
    logic [SEC_W-1:0] sec_num;
    logic [31:0]      arg_r;
    err_e             err_r;
    logic             xfer;

    assign spi_req    = (st != ST_IDLE) && (st != ST_END);
    assign xfer       = spi_req && spi_ack;
    assign in_frame   = (st == ST_CMD);
    assign frame_stop = stop_r;
    assign frame_pos  = pos_r;
    assign frame_arg  = arg_r;
    assign push       = xfer && (st == ST_DATA);
    assign push_idx   = idx_r;
    assign push_sec   = sec_num;
    assign done       = (st == ST_END);
    assign err_code   = err_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            stop_r   <= 1'b0;
            pos_r    <= '0;
            cnt      <= '0;
            lim_r    <= DEF_L;
            idx_r    <= '0;
            chk_k    <= 1'b0;
            sec_left <= '0;
            sec_num  <= '0;
            arg_r    <= '0;
            err_r    <= ERR_NONE;
            cs_low   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        err_r <= ERR_NONE;
                        if (sector_cnt == '0) begin
                            st <= ST_END;
                        end else begin
                            st       <= ST_CMD;
                            cs_low   <= 1'b1;
                            stop_r   <= 1'b0;
                            pos_r    <= '0;
                            sec_left <= sector_cnt;
                            sec_num  <= '0;
                            arg_r    <= sector_addr;
                            lim_r    <= (tok_limit == '0) ? DEF_L : tok_limit;
                        end
                    end
                end
                ST_CMD: begin
                    if (xfer) begin
                        if (pos_r == 3'(FRAME_LEN - 1)) begin
                            st  <= ST_RESP;
                            cnt <= '0;
                        end else begin
                            pos_r <= pos_r + 3'd1;
                        end
                    end
                end
                ST_RESP: begin
                    if (xfer) begin
                        if (!spi_rx[7]) begin
                            if (spi_rx != 8'h00) begin
                                if (err_r == ERR_NONE) err_r <= ERR_RESP;
                                st     <= ST_END;
                                cs_low <= 1'b0;
                            end else if (stop_r) begin
                                st <= ST_BUSY;
                            end else begin
                                st  <= ST_HUNT;
                                cnt <= '0;
                            end
                        end else if (cnt == POLL_LAST) begin
                            if (err_r == ERR_NONE) err_r <= ERR_SILENT;
                            st     <= ST_END;
                            cs_low <= 1'b0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_HUNT: begin
                    if (xfer) begin
                        if (spi_rx == START_MARK) begin
                            st    <= ST_DATA;
                            idx_r <= '0;
                        end else if (cnt == lim_r - 1'b1) begin
                            err_r  <= ERR_MARK;
                            st     <= ST_CMD;
                            stop_r <= 1'b1;
                            pos_r  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (idx_r == IDX_LAST) begin
                            st    <= ST_CHK;
                            chk_k <= 1'b0;
                        end else begin
                            idx_r <= idx_r + 1'b1;
                        end
                    end
                end
                ST_CHK: begin
                    if (xfer) begin
                        if (chk_k) begin
                            sec_left <= sec_left - 1'b1;
                            sec_num  <= sec_num + 1'b1;
                            if (sec_left == SEC_W'(1)) begin
                                st     <= ST_CMD;
                                stop_r <= 1'b1;
                                pos_r  <= '0;
                            end else begin
                                st  <= ST_HUNT;
                                cnt <= '0;
                            end
                        end else begin
                            chk_k <= 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (xfer && (spi_rx != 8'h00)) begin
                        st     <= ST_END;
                        cs_low <= 1'b0;
                    end
                end
                ST_END: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sd_mbr_outstage.sv
module sd_mbr_outstage
    import sd_mbr_pkg::*;
#(
    parameter int SEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [SEC_W-1:0] push_sec,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [IDX_W-1:0] out_idx,
    output logic [SEC_W-1:0] out_sector
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_idx    <= '0;
            out_sector <= '0;
        end else begin
            out_valid <= push;
            if (push) begin
                out_data   <= push_data;
                out_idx    <= push_idx;
                out_sector <= push_sec;
            end
        end
    end

endmodule

// File: rtl/sd_mbr_engine.sv
module sd_mbr_engine
    import sd_mbr_pkg::*;
#(
    parameter int SEC_W       = 16,
    parameter int LIM_W       = 16,
    parameter int DEF_LIMIT   = 8192,
    parameter int R1_POLL_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      sector_addr,
    input  logic [SEC_W-1:0] sector_cnt,
    input  logic [LIM_W-1:0] tok_limit,
    output logic             spi_cs_n,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [8:0]       out_idx,
    output logic [SEC_W-1:0] out_sector,
    output logic             done,
    output logic [1:0]       err_code
);

    logic             in_frame;
    logic             frame_stop;
    logic [2:0]       frame_pos;
    logic [31:0]      frame_arg;
    logic [7:0]       frame_byte;
    logic             cs_low;
    logic             push;
    logic [IDX_W-1:0] push_idx;
    logic [SEC_W-1:0] push_sec;

    sd_mbr_seq #(
        .SEC_W(SEC_W), .LIM_W(LIM_W),
        .DEF_LIMIT(DEF_LIMIT), .R1_POLL_MAX(R1_POLL_MAX)
    ) seq_i (
        .clk(clk), .rst(rst), .start(start),
        .sector_addr(sector_addr), .sector_cnt(sector_cnt), .tok_limit(tok_limit),
        .spi_ack(spi_ack), .spi_rx(spi_rx), .spi_req(spi_req),
        .in_frame(in_frame), .frame_stop(frame_stop), .frame_pos(frame_pos),
        .frame_arg(frame_arg), .cs_low(cs_low),
        .push(push), .push_idx(push_idx), .push_sec(push_sec),
        .done(done), .err_code(err_code)
    );

    sd_mbr_cmdgen cmd_i (
        .is_stop(frame_stop), .arg(frame_arg), .pos(frame_pos),
        .frame_byte(frame_byte)
    );

    sd_mbr_outstage #(.SEC_W(SEC_W)) out_i (
        .clk(clk), .rst(rst), .push(push), .push_data(spi_rx),
        .push_idx(push_idx), .push_sec(push_sec),
        .out_valid(out_valid), .out_data(out_data),
        .out_idx(out_idx), .out_sector(out_sector)
    );

    assign spi_tx   = in_frame ? frame_byte : FILL_BYTE;
    assign spi_cs_n = ~cs_low;

endmodule

// File: rtl/sd_mbr_chk.sv
module sd_mbr_chk (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_req,
    input logic [7:0] spi_tx,
    input logic       spi_ack,
    input logic       done
);

    // R2 / R8: no exchange without the card selected
    assert_req_selected_R2: assert property (@(posedge clk) disable iff (rst)
        spi_req |-> !spi_cs_n);

    // R9: done only with the card released
    assert_done_released_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: release of chip select coincides with done
    assert_release_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> done);

    // R11: pending request and its byte hold until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

endmodule

bind sd_mbr_engine sd_mbr_chk chk_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_req(spi_req),
    .spi_tx(spi_tx), .spi_ack(spi_ack), .done(done)
);

// File: tb/sd_mbr_engine_tb_top.sv
module sd_mbr_engine_tb_top;

    typedef struct packed {
        logic [15:0] secs;
        logic [31:0] addr;
        logic [15:0] gap;
        logic [7:0]  r1;
        logic [7:0]  r1dly;
        logic [7:0]  busy;
        logic [15:0] lim;
        logic [7:0]  lat;
        logic [1:0]  experr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd1, 32'h0000_1234, 16'd3,  8'h00, 8'd1,  8'd2, 16'd0,  8'd0, 2'd0},
        '{16'd3, 32'hA5C3_0F01, 16'd10, 8'h00, 8'd2,  8'd0, 16'd0,  8'd3, 2'd0},
        '{16'd2, 32'h7E00_00FE, 16'd0,  8'h00, 8'd1,  8'd5, 16'd0,  8'd0, 2'd0},
        '{16'd1, 32'h0000_0042, 16'd3,  8'h04, 8'd1,  8'd0, 16'd0,  8'd0, 2'd2},
        '{16'd1, 32'h0000_0010, 16'd20, 8'h00, 8'd1,  8'd1, 16'd20, 8'd0, 2'd1},
        '{16'd1, 32'h0000_0011, 16'd20, 8'h00, 8'd1,  8'd1, 16'd21, 8'd1, 2'd0},
        '{16'd1, 32'h0000_0012, 16'd3,  8'h00, 8'd10, 8'd0, 16'd0,  8'd0, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] sector_addr = '0;
    logic [15:0] sector_cnt = '0;
    logic [15:0] tok_limit = '0;
    logic        spi_cs_n, spi_req, out_valid, done;
    logic [7:0]  spi_tx, out_data;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = 8'hFF;
    logic [8:0]  out_idx;
    logic [15:0] out_sector;
    logic [1:0]  err_code;

    always #2.5 clk = ~clk;

    sd_mbr_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .sector_addr(sector_addr),
        .sector_cnt(sector_cnt), .tok_limit(tok_limit),
        .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx),
        .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx),
        .out_sector(out_sector), .done(done), .err_code(err_code)
    );

    int total = 0;
    int bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 29) + (i * 7) + (i / 256) + 5);
    endfunction

    // ---------------- card model ----------------
    localparam int M_IDLE = 0, M_RESP = 1, M_GAP = 2, M_DATA = 3, M_BUSY = 4;
    int c_mode, c_cnt, c_idx, c_sec, c_wait, c_fr_n;
    int c_gap, c_dly, c_busy, c_lat;
    logic [7:0] c_r1, c_txw;
    logic       c_stop;
    logic [7:0] fr [6];
    logic [7:0] got18 [6];
    logic [7:0] got12 [6];
    int seen18, seen12, n_xfer, fill_bad, hold_bad;

    always @(negedge clk) begin
        if (spi_ack) begin
            spi_ack = 1'b0;
        end else if (spi_req) begin
            if (c_wait == 0) c_txw = spi_tx;
            else if (spi_tx !== c_txw) hold_bad++;
            if (c_wait < c_lat) begin
                c_wait++;
            end else begin
                c_wait = 0;
                n_xfer++;
                case (c_mode)
                    M_RESP: begin
                        if (c_cnt > 0) begin spi_rx = 8'hFF; c_cnt--; end
                        else begin
                            spi_rx = c_r1;
                            if (c_r1 != 8'h00) c_mode = M_IDLE;
                            else if (c_stop) begin c_mode = M_BUSY; c_cnt = c_busy; end
                            else begin c_mode = M_GAP; c_cnt = c_gap; end
                        end
                    end
                    M_GAP: begin
                        if (c_cnt > 0) begin spi_rx = 8'hFF; c_cnt--; end
                        else begin spi_rx = 8'hFE; c_mode = M_DATA; c_idx = 0; end
                    end
                    M_DATA: begin
                        spi_rx = (c_idx < 512) ? pat(c_sec, c_idx) : 8'h5A;
                        c_idx++;
                        if (c_idx == 514) begin c_sec++; c_mode = M_GAP; c_cnt = c_gap; end
                    end
                    M_BUSY: begin
                        if (c_cnt > 0) begin spi_rx = 8'h00; c_cnt--; end
                        else begin spi_rx = 8'hFF; c_mode = M_IDLE; end
                    end
                    default: spi_rx = 8'hFF;
                endcase
                // frame parsing
                if (c_fr_n == 0 && spi_tx[7:6] == 2'b01) begin
                    fr[0] = spi_tx; c_fr_n = 1;
                end else if (c_fr_n > 0) begin
                    fr[c_fr_n] = spi_tx; c_fr_n++;
                    if (c_fr_n == 6) begin
                        c_fr_n = 0;
                        if (fr[0] == 8'h52) begin
                            for (int i = 0; i < 6; i++) got18[i] = fr[i];
                            seen18++; c_stop = 1'b0; c_sec = 0;
                            c_mode = M_RESP; c_cnt = c_dly;
                        end else begin
                            for (int i = 0; i < 6; i++) got12[i] = fr[i];
                            seen12++; c_stop = 1'b1;
                            c_mode = M_RESP; c_cnt = 1;
                        end
                    end
                end else if (spi_tx !== 8'hFF) begin
                    fill_bad++;
                end
                spi_ack = 1'b1;
            end
        end
    end

    // ---------------- output monitor ----------------
    int d_cnt, d_bad, exp_i, exp_s, done_cnt, done_cs_bad;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (out_data !== pat(exp_s, exp_i) || out_idx !== 9'(exp_i)
                    || out_sector !== 16'(exp_s)) d_bad++;
                d_cnt++;
                exp_i++;
                if (exp_i == 512) begin exp_i = 0; exp_s++; end
            end
            if (done) begin
                done_cnt++;
                if (spi_cs_n !== 1'b1) done_cs_bad++;
            end
        end
    end

    task automatic clear_run();
        c_mode = M_IDLE; c_cnt = 0; c_idx = 0; c_sec = 0; c_wait = 0; c_fr_n = 0;
        c_stop = 1'b0; seen18 = 0; seen12 = 0; n_xfer = 0; fill_bad = 0; hold_bad = 0;
        d_cnt = 0; d_bad = 0; exp_i = 0; exp_s = 0; done_cnt = 0; done_cs_bad = 0;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        ok = 1'b1;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (n > 40000) begin ok = 1'b0; break; end
        end
    endtask

    initial begin
        bit ok;
        clear_run();
        c_gap = 0; c_dly = 1; c_busy = 0; c_lat = 0; c_r1 = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(spi_cs_n === 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
        check(spi_req === 1'b0 && done === 1'b0 && out_valid === 1'b0,
              "R1 req/done/valid", int'({spi_req, done, out_valid}), 0);
        check(err_code === 2'd0, "R1 err_code", int'(err_code), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            clear_run();
            c_gap = int'(VECS[v].gap); c_dly = int'(VECS[v].r1dly);
            c_busy = int'(VECS[v].busy); c_lat = int'(VECS[v].lat); c_r1 = VECS[v].r1;
            sector_addr = VECS[v].addr; sector_cnt = VECS[v].secs; tok_limit = VECS[v].lim;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(ok);
            check(ok, "R9 finish before watchdog", v, v);
            check(err_code === VECS[v].experr, "R4/R6 err_code", int'(err_code), int'(VECS[v].experr));
            repeat (6) @(negedge clk);
            check(err_code === VECS[v].experr, "R9 err held", int'(err_code), int'(VECS[v].experr));
            check(done_cnt == 1 && done_cs_bad == 0, "R9 done pulse", done_cnt, 1);
            check(spi_cs_n === 1'b1 && spi_req === 1'b0, "R8 released", int'(spi_cs_n), 1);
            check(seen18 == 1 && got18[0] == 8'h52 && got18[5] == 8'hFF, "R2 read frame", seen18, 1);
            check({got18[1], got18[2], got18[3], got18[4]} == VECS[v].addr, "R2 address order",
                  int'({got18[1], got18[2], got18[3], got18[4]}), int'(VECS[v].addr));
            check(fill_bad == 0, "R3 fill bytes", fill_bad, 0);
            check(hold_bad == 0, "R11 request hold", hold_bad, 0);
            if (VECS[v].experr == 2'd0) begin
                check(d_cnt == 512 * int'(VECS[v].secs), "R5/R7 byte count", d_cnt, 512 * int'(VECS[v].secs));
                check(d_bad == 0, "R5 payload order", d_bad, 0);
            end else begin
                check(d_cnt == 0, "R4/R6 no payload on error", d_cnt, 0);
            end
            if (VECS[v].experr == 2'd0 || VECS[v].experr == 2'd1) begin
                check(seen12 == 1 && got12[0] == 8'h4C && got12[1] == 8'h00 && got12[4] == 8'h00
                      && got12[5] == 8'hFF, "R8/R6 stop frame", seen12, 1);
            end else begin
                check(seen12 == 0, "R4 no stop frame", seen12, 0);
            end
            if (VECS[v].experr == 2'd0 && VECS[v].busy != 0)
                check(c_mode == M_IDLE && c_cnt == 0, "R8 busy drained", c_cnt, 0);
        end

        // R10: zero sectors
        clear_run();
        sector_cnt = 16'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1 && err_code === 2'd0, "R10 immediate done", int'(done), 1);
        check(n_xfer == 0 && spi_cs_n === 1'b1, "R10 no exchange", n_xfer, 0);
        @(negedge clk);
        check(done === 1'b0, "R9 zero-sector pulse", int'(done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule